// File: doc/BRIEF.md
# Programmable Interval Timer with Masked Interrupt and Error Flags

This block is a one-shot interval timer that runs on the reference clock. It is combined with two maskable flag outputs. A 13-bit period value sets the delay in reference-clock cycles. Two enable bits select what arms the timer: a pulse on the start measurement input, a pulse on the stop measurement input, or a pulse on either one. When the programmed number of cycles has elapsed, the timer sets a sticky end-of-timer bit. That bit stays set until a clear strobe or a reset removes it.

The flag logic gathers a set of status events. Hit FIFO full, interface FIFO full, PLL not locked and all hit FIFOs empty come from neighbouring logic. The end-of-timer bit comes from this block. Each event is gated by its own mask bit, and the gated events are ORed into an interrupt flag. A smaller set of events is gated by a second mask and ORed into an error flag. Both flags are registered.

Top module: `ivt_flag_unit`

## Requirements
- R1: While reset is asserted and right after it, `timer_busy`, `expiry_sticky`, `irq_flag` and `err_flag` are all 0.
- R2: An idle timer starts on the clock edge where `start_evt` is high with `arm_on_start` set, or `stop_evt` is high with `arm_on_stop` set. A pulse whose enable bit is clear does not start it.
- R3: After a start edge, `timer_busy` stays high for exactly N cycles, where N is the period. `expiry_sticky` becomes 1 on the N-th edge after the start edge.
- R4: A period value of 0 behaves like a period of 1.
- R5: A trigger that arrives while the timer is running is ignored. The expiry timing of the current run does not change.
- R6: `expiry_sticky` stays at 1 until an edge where `expiry_clr` is high. If an expiry and a clear occur on the same edge, the expiry wins.
- R7: `irq_flag` is the OR of the events gated by `irq_mask`. Bit 0 is any `hit_full` bit, bit 1 is any `ifc_full` bit, bit 2 is `pll_unlock`, bit 3 is all `hit_empty` bits set, and bit 4 is `expiry_sticky`. A mask bit of 1 enables its event.
- R8: `err_flag` is the OR of the events gated by `err_mask`. Bit 0 is any `hit_full` bit, bit 1 is any `ifc_full` bit, and bit 2 is `pll_unlock`. A mask bit of 1 enables its event.
- R9: Each flag shows its new value one clock edge after its inputs change, never in the same cycle.
- R10: The largest period, 8191, gives a run of 8191 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_evt | input | 1 | Start-input event pulse |
| stop_evt | input | 1 | Stop-input event pulse |
| arm_on_start | input | 1 | Lets `start_evt` start the timer |
| arm_on_stop | input | 1 | Lets `stop_evt` start the timer |
| period | input | 13 | Delay in reference cycles (0 is taken as 1) |
| expiry_clr | input | 1 | Clears the sticky end-of-timer bit |
| hit_full | input | 8 | Full status, one bit per hit FIFO |
| ifc_full | input | 2 | Full status, one bit per interface FIFO |
| hit_empty | input | 8 | Empty status, one bit per hit FIFO |
| pll_unlock | input | 1 | PLL not locked |
| irq_mask | input | 5 | Interrupt event enables |
| err_mask | input | 3 | Error event enables |
| timer_busy | output | 1 | Timer is counting |
| expiry_sticky | output | 1 | Sticky end-of-timer status |
| irq_flag | output | 1 | Registered interrupt flag |
| err_flag | output | 1 | Registered error flag |

## Verification
The assertions assume that the status and mask inputs are stable from the sampling edge onward. They also assume that `period` does not change on the edge where a trigger is accepted, because the run-length check latches it there. The bench meets both conditions by changing every input only on the falling clock edge. It holds `period` constant for the whole of each timer run. Triggers are single-cycle pulses. The only exceptions are the deliberate re-trigger during a run and the clear held across an expiry edge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    // Interrupt event positions; the mask bits follow the same order.
    localparam int IRQ_HIT_FULL  = 0;
    localparam int IRQ_IFC_FULL  = 1;
    localparam int IRQ_PLL_LOST  = 2;
    localparam int IRQ_ALL_EMPTY = 3;
    localparam int IRQ_TIMER_END = 4;
    localparam int N_IRQ_EV      = 5;
    // Error event positions.
    localparam int ERR_HIT_FULL  = 0;
    localparam int ERR_IFC_FULL  = 1;
    localparam int ERR_PLL_LOST  = 2;
    localparam int N_ERR_EV      = 3;
endpackage

// File: rtl/ivt_trigger_sel.sv
module ivt_trigger_sel (
    input  logic start_evt,
    input  logic stop_evt,
    input  logic arm_on_start,
    input  logic arm_on_stop,
    output logic trig
);
    always_comb begin
        trig = (start_evt && arm_on_start) || (stop_evt && arm_on_stop);
    end
endmodule

// File: rtl/ivt_countdown.sv
module ivt_countdown #(
    parameter int PW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic [PW-1:0] period,
    input  logic          clr,
    output logic          busy,
    output logic          done
);
    typedef struct packed {
        logic          busy;
        logic [PW-1:0] cnt;
        logic          done;
    } cd_state_t;

    localparam logic [PW-1:0] ONE = PW'(1);

    cd_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = st_q.done & ~clr;
        if (st_q.busy) begin
            if (st_q.cnt <= ONE) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end else if (trig) begin
            st_d.busy = 1'b1;
            st_d.cnt  = (period == '0) ? ONE : period;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign done = st_q.done;
endmodule

// File: rtl/ivt_masked_or.sv
module ivt_masked_or #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] mask,
    output logic         flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = |(ev & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/ivt_flag_unit.sv
module ivt_flag_unit
    import ivt_pkg::*;
#(
    parameter int PW     = 13,
    parameter int N_HIT  = 8,
    parameter int N_IFC  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_evt,
    input  logic                stop_evt,
    input  logic                arm_on_start,
    input  logic                arm_on_stop,
    input  logic [PW-1:0]       period,
    input  logic                expiry_clr,
    input  logic [N_HIT-1:0]    hit_full,
    input  logic [N_IFC-1:0]    ifc_full,
    input  logic [N_HIT-1:0]    hit_empty,
    input  logic                pll_unlock,
    input  logic [N_IRQ_EV-1:0] irq_mask,
    input  logic [N_ERR_EV-1:0] err_mask,
    output logic                timer_busy,
    output logic                expiry_sticky,
    output logic                irq_flag,
    output logic                err_flag
);
    logic                trig;
    logic [N_IRQ_EV-1:0] irq_ev;
    logic [N_ERR_EV-1:0] err_ev;

    ivt_trigger_sel u_trig (
        .start_evt    (start_evt),
        .stop_evt     (stop_evt),
        .arm_on_start (arm_on_start),
        .arm_on_stop  (arm_on_stop),
        .trig         (trig)
    );

    ivt_countdown #(.PW(PW)) u_cd (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig),
        .period (period),
        .clr    (expiry_clr),
        .busy   (timer_busy),
        .done   (expiry_sticky)
    );

    always_comb begin
        irq_ev                = '0;
        irq_ev[IRQ_HIT_FULL]  = |hit_full;
        irq_ev[IRQ_IFC_FULL]  = |ifc_full;
        irq_ev[IRQ_PLL_LOST]  = pll_unlock;
        irq_ev[IRQ_ALL_EMPTY] = &hit_empty;
        irq_ev[IRQ_TIMER_END] = expiry_sticky;
        err_ev                = '0;
        err_ev[ERR_HIT_FULL]  = |hit_full;
        err_ev[ERR_IFC_FULL]  = |ifc_full;
        err_ev[ERR_PLL_LOST]  = pll_unlock;
    end

    ivt_masked_or #(.N(N_IRQ_EV)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (irq_ev),
        .mask  (irq_mask),
        .flag  (irq_flag)
    );

    ivt_masked_or #(.N(N_ERR_EV)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (err_ev),
        .mask  (err_mask),
        .flag  (err_flag)
    );
endmodule

// File: rtl/ivt_flag_unit_chk.sv
module ivt_flag_unit_chk
    import ivt_pkg::*;
#(
    parameter int PW    = 13,
    parameter int N_HIT = 8,
    parameter int N_IFC = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_evt,
    input logic                stop_evt,
    input logic                arm_on_start,
    input logic                arm_on_stop,
    input logic [PW-1:0]       period,
    input logic                expiry_clr,
    input logic [N_HIT-1:0]    hit_full,
    input logic [N_IFC-1:0]    ifc_full,
    input logic [N_HIT-1:0]    hit_empty,
    input logic                pll_unlock,
    input logic [N_IRQ_EV-1:0] irq_mask,
    input logic [N_ERR_EV-1:0] err_mask,
    input logic                timer_busy,
    input logic                expiry_sticky,
    input logic                irq_flag,
    input logic                err_flag
);
    logic          past_ok;
    logic          trig_c;
    logic          irq_want, err_want;
    logic [PW:0]   run_len;
    logic [PW-1:0] per_lat;

    assign trig_c   = (start_evt && arm_on_start) || (stop_evt && arm_on_stop);
    assign irq_want = |({expiry_sticky, &hit_empty, pll_unlock, |ifc_full, |hit_full} & irq_mask);
    assign err_want = |({pll_unlock, |ifc_full, |hit_full} & err_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            run_len <= '0;
            per_lat <= '0;
        end else begin
            past_ok <= 1'b1;
            if (!timer_busy && trig_c) begin
                run_len <= '0;
                per_lat <= (period == '0) ? PW'(1) : period;
            end else if (timer_busy) begin
                run_len <= run_len + 1'b1;
            end
        end
    end

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> irq_flag == $past(irq_want)); // R7
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> err_flag == $past(err_want)); // R8
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timer_busy) |-> run_len == {1'b0, per_lat}); // R3
    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_busy) |-> $past(trig_c)); // R2
    AST_END_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expiry_sticky) |-> $past(timer_busy)); // R3
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && expiry_sticky && !expiry_clr |=> expiry_sticky); // R6
endmodule

bind ivt_flag_unit ivt_flag_unit_chk #(.PW(PW), .N_HIT(N_HIT), .N_IFC(N_IFC)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .arm_on_start(arm_on_start), .arm_on_stop(arm_on_stop), .period(period),
    .expiry_clr(expiry_clr), .hit_full(hit_full), .ifc_full(ifc_full),
    .hit_empty(hit_empty), .pll_unlock(pll_unlock), .irq_mask(irq_mask),
    .err_mask(err_mask), .timer_busy(timer_busy), .expiry_sticky(expiry_sticky),
    .irq_flag(irq_flag), .err_flag(err_flag)
);

// File: tb/ivt_flag_unit_tb.sv
module ivt_flag_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_evt = 0, stop_evt = 0, arm_on_start = 0, arm_on_stop = 0;
    logic [12:0] period = '0;
    logic        expiry_clr = 0;
    logic [7:0]  hit_full = '0, hit_empty = '0;
    logic [1:0]  ifc_full = '0;
    logic        pll_unlock = 0;
    logic [4:0]  irq_mask = '0;
    logic [2:0]  err_mask = '0;
    logic        timer_busy, expiry_sticky, irq_flag, err_flag;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ivt_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .arm_on_start(arm_on_start), .arm_on_stop(arm_on_stop), .period(period),
        .expiry_clr(expiry_clr), .hit_full(hit_full), .ifc_full(ifc_full),
        .hit_empty(hit_empty), .pll_unlock(pll_unlock), .irq_mask(irq_mask),
        .err_mask(err_mask), .timer_busy(timer_busy), .expiry_sticky(expiry_sticky),
        .irq_flag(irq_flag), .err_flag(err_flag)
    );

    // {hit_full, ifc_full, hit_empty, pll, irq_mask, err_mask, exp_irq, exp_err}
    localparam int NV = 10;
    localparam logic [28:0] VEC [NV] = '{
        {8'h00, 2'b00, 8'h00, 1'b0, 5'h1F, 3'h7, 1'b0, 1'b0},
        {8'h01, 2'b00, 8'h00, 1'b0, 5'h01, 3'h0, 1'b1, 1'b0},
        {8'h80, 2'b00, 8'h00, 1'b0, 5'h1E, 3'h1, 1'b0, 1'b1},
        {8'h00, 2'b10, 8'h00, 1'b0, 5'h02, 3'h0, 1'b1, 1'b0},
        {8'h00, 2'b01, 8'h00, 1'b0, 5'h00, 3'h2, 1'b0, 1'b1},
        {8'h00, 2'b00, 8'h00, 1'b1, 5'h04, 3'h4, 1'b1, 1'b1},
        {8'h00, 2'b00, 8'h00, 1'b1, 5'h1B, 3'h3, 1'b0, 1'b0},
        {8'h00, 2'b00, 8'hFF, 1'b0, 5'h08, 3'h7, 1'b1, 1'b0},
        {8'h00, 2'b00, 8'h7F, 1'b0, 5'h08, 3'h7, 1'b0, 1'b0},
        {8'h00, 2'b00, 8'hFF, 1'b0, 5'h17, 3'h0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_sticky();
        expiry_clr = 1;
        tick();
        expiry_clr = 0;
    endtask

    // Pulse a trigger, then count edges until expiry_sticky rises.
    task automatic run_len(input bit use_stop, input bit retrig, output int n);
        if (use_stop) stop_evt = 1; else start_evt = 1;
        tick();
        start_evt = 0;
        stop_evt  = 0;
        n = 0;
        while (!expiry_sticky && n < 9000) begin
            if (retrig && n == 2) start_evt = 1;
            tick();
            start_evt = 0;
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk);
        // R1: reset state
        check("R1 busy", timer_busy, 0);
        check("R1 sticky", expiry_sticky, 0);
        check("R1 irq", irq_flag, 0);
        check("R1 err", err_flag, 0);
        tick();
        rst_n = 1;
        tick();
        check("R1 busy after release", timer_busy, 0);

        // R7 / R8: masked OR vectors
        for (int i = 0; i < NV; i++) begin
            {hit_full, ifc_full, hit_empty, pll_unlock, irq_mask, err_mask} = VEC[i][28:2];
            tick();
            check($sformatf("R7 irq vec %0d", i), irq_flag, VEC[i][1]);
            check($sformatf("R8 err vec %0d", i), err_flag, VEC[i][0]);
        end
        hit_full = '0; ifc_full = '0; hit_empty = '0; pll_unlock = 0;
        irq_mask = '0; err_mask = '0;
        tick();

        // R9: no same-cycle change, visible after one edge
        pll_unlock = 1; irq_mask = 5'h04; err_mask = 3'h4;
        #1;
        check("R9 irq before edge", irq_flag, 0);
        check("R9 err before edge", err_flag, 0);
        tick();
        check("R9 irq after edge", irq_flag, 1);
        check("R9 err after edge", err_flag, 1);
        pll_unlock = 0; irq_mask = '0; err_mask = '0;
        tick();

        // R2: disabled triggers do nothing
        period = 13'd5;
        start_evt = 1; stop_evt = 1;
        tick();
        start_evt = 0; stop_evt = 0;
        check("R2 no enable no start", timer_busy, 0);

        // R2 / R3: start input
        arm_on_start = 1;
        run_len(0, 0, n);
        check("R3 start period 5", n, 5);
        check("R3 busy clear at expiry", timer_busy, 0);
        irq_mask = 5'h10;
        tick();
        check("R7 timer end irq", irq_flag, 1);
        irq_mask = '0;
        clear_sticky();
        check("R6 clear strobe", expiry_sticky, 0);

        // R2: stop input ignored when only start is armed
        stop_evt = 1;
        tick();
        stop_evt = 0;
        check("R2 stop not armed", timer_busy, 0);

        // R2: stop input armed
        arm_on_start = 0; arm_on_stop = 1; period = 13'd3;
        run_len(1, 0, n);
        check("R2 stop period 3", n, 3);
        clear_sticky();

        // R4: zero period
        arm_on_start = 1; period = 13'd0;
        run_len(0, 0, n);
        check("R4 zero period", n, 1);

        // R6: sticky holds
        repeat (20) tick();
        check("R6 sticky held", expiry_sticky, 1);
        clear_sticky();

        // R5: retrigger during run ignored
        period = 13'd10;
        run_len(0, 1, n);
        check("R5 retrigger ignored", n, 10);
        clear_sticky();

        // R6: set beats clear on the same edge
        period = 13'd1;
        start_evt = 1;
        tick();
        start_evt = 0;
        expiry_clr = 1;
        tick();
        expiry_clr = 0;
        check("R6 set wins over clear", expiry_sticky, 1);
        clear_sticky();

        // R10: maximum period
        period = 13'd8191;
        run_len(0, 0, n);
        check("R10 max period", n, 8191);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule